// File: doc/BRIEF.md
# Off-State Load Diagnostic Sequencer

This block runs a passive off-state check on one pair of half-bridge outputs while every bridge is switched off. A start pulse latches a 4-bit pair selector. The selector is decoded into two output indices, X and Y. The block then applies three bias patterns in a fixed order. Each pattern drives internal pull-up and pull-down enables on X and Y, picks which of the two outputs feeds the comparator, and selects the high or low comparator reference. Each pattern is held for a programmable settling time. At the end of that time the comparator output, which is not latched, is sampled once.

The three samples form a signature, and the block maps that signature to a fault class. The class is reported with a one-cycle done pulse. If any bridge is enabled, all bias is removed in the same cycle and a running check is aborted.

The block has no data stream, so it has no valid/ready interface. Every pin is a plain level or pulse control, and nothing at its edge waits for back-pressure. Output number n (1 to 6) is bit n-1 of every per-output vector.

Top module: `odiag_offstate_seq`

## Requirements
- R1: After reset, busy_o and done_o are low, result_o is 0 (none), and all of pu_en_o, pd_en_o, cmp_mux_o and ref_high_o are zero.
- R2: A nonzero pair selector k picks the k-th pair (X,Y) with X<Y when the pairs of outputs 1..6 are listed in lexicographic order: 1 gives (1,2), 2 gives (1,3), 5 gives (1,6), 6 gives (2,3), and 15 gives (5,6).
- R3: In the first step, the pull-up of X and the pull-down of Y are on, cmp_mux_o selects Y, and ref_high_o is 0.
- R4: In the second step, the pull-up of X and the pull-down of Y are on, cmp_mux_o selects X, and ref_high_o is 1.
- R5: In the third step, the pull-down of X and the pull-up of Y are on, cmp_mux_o selects Y, and ref_high_o is 0.
- R6: The first step begins in the cycle after the start edge. Each step lasts S+1 cycles, where S is settle_cycles_i as captured on the edge that starts that step. cmp_i is sampled only on the edge that ends each step.
- R7: The samples (first, second, third) are classified as follows: 1,0,1 is normal (1); 0,1,1 is open (2); 0,0,0 is short to ground (3); 1,1,1 is short to supply (4); any other pattern is indeterminate (5).
- R8: done_o is high for exactly one cycle, and result_o takes its new value in that same cycle and holds it until the next completion. busy_o is high from the cycle after the start through the last step, and is low in the done cycle.
- R9: A start with a pair selector of 0 gives done with result 0 in the next cycle and applies no bias.
- R10: While any bit of hb_en_i is 1, all bias outputs and cmp_mux_o are zero in that same cycle. A running sequence ends with done and result 6 (aborted) on the next edge.
- R11: A start while any bridge is enabled gives done with result 6 in the next cycle and applies no bias.
- R12: A start while busy is ignored, and the running pair and timing are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a check |
| pair_sel_i | input | 4 | Pair selector, 0 means no pair |
| settle_cycles_i | input | 8 | Settling time S per step (step lasts S+1 cycles) |
| hb_en_i | input | 6 | Half-bridge enable bits, one per output |
| cmp_i | input | 1 | Unlatched comparator output |
| pu_en_o | output | 6 | Pull-up enables, one per output |
| pd_en_o | output | 6 | Pull-down enables, one per output |
| cmp_mux_o | output | 6 | One-hot selection of the output that feeds the comparator |
| ref_high_o | output | 1 | 1 selects the high reference, 0 the low |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 3 | Fault class (0 none, 1 normal, 2 open, 3 short to ground, 4 short to supply, 5 indeterminate, 6 aborted) |

## Verification
The bench drives the comparator with the inverted value on every cycle except the last cycle of each step. A design that samples early, or late by one cycle, then classifies the wrong fault. The settling value is changed right after the start, so a design that keeps the first value for all three steps ends at the wrong cycle. Aborts mid-run, starts with a bridge enabled, and a zero selector all check that bias drops in the same cycle and that exactly one done pulse carries the right code. A second start during a run must leave the running pair untouched, or the bias vectors mismatch.

// File: rtl/odiag_pkg.sv
package odiag_pkg;
  typedef enum logic [2:0] {
    RES_NONE      = 3'd0,
    RES_NORMAL    = 3'd1,
    RES_OPEN      = 3'd2,
    RES_SHORT_GND = 3'd3,
    RES_SHORT_SUP = 3'd4,
    RES_UNKNOWN   = 3'd5,
    RES_ABORT     = 3'd6
  } diag_res_e;

  typedef enum logic [1:0] {
    BIAS_OFF       = 2'b00,
    BIAS_XUP_SNS_Y = 2'b01,
    BIAS_XUP_SNS_X = 2'b10,
    BIAS_YUP_SNS_Y = 2'b11
  } bias_code_e;
endpackage

// File: rtl/odiag_pair_decode.sv
module odiag_pair_decode #(
  parameter int NUM_OUT = 6,
  parameter int SEL_W   = 4,
  parameter int IDX_W   = 3
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] x_idx_o,
  output logic [IDX_W-1:0] y_idx_o
);
  // Walk the pairs in lexicographic order; the k-th hit is the selection.
  always_comb begin
    int k;
    k       = 0;
    valid_o = 1'b0;
    x_idx_o = '0;
    y_idx_o = '0;
    for (int a = 0; a < NUM_OUT - 1; a++) begin
      for (int b = a + 1; b < NUM_OUT; b++) begin
        k = k + 1;
        if (k == int'(sel_i)) begin
          valid_o = 1'b1;
          x_idx_o = IDX_W'(a);
          y_idx_o = IDX_W'(b);
        end
      end
    end
  end
endmodule

// File: rtl/odiag_bias_map.sv
module odiag_bias_map
  import odiag_pkg::*;
#(
  parameter int NUM_OUT = 6,
  parameter int IDX_W   = 3
) (
  input  bias_code_e         code_i,
  input  logic [IDX_W-1:0]   x_idx_i,
  input  logic [IDX_W-1:0]   y_idx_i,
  output logic [NUM_OUT-1:0] pu_o,
  output logic [NUM_OUT-1:0] pd_o,
  output logic [NUM_OUT-1:0] mux_o,
  output logic               ref_high_o
);
  always_comb begin
    pu_o       = '0;
    pd_o       = '0;
    mux_o      = '0;
    ref_high_o = 1'b0;
    case (code_i)
      BIAS_XUP_SNS_Y: begin
        pu_o[x_idx_i]  = 1'b1;
        pd_o[y_idx_i]  = 1'b1;
        mux_o[y_idx_i] = 1'b1;
      end
      BIAS_XUP_SNS_X: begin
        pu_o[x_idx_i]  = 1'b1;
        pd_o[y_idx_i]  = 1'b1;
        mux_o[x_idx_i] = 1'b1;
        ref_high_o     = 1'b1;
      end
      BIAS_YUP_SNS_Y: begin
        pd_o[x_idx_i]  = 1'b1;
        pu_o[y_idx_i]  = 1'b1;
        mux_o[y_idx_i] = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/odiag_classify.sv
module odiag_classify
  import odiag_pkg::*;
(
  input  logic [2:0] sig_i,   // {first, second, third} sample
  output diag_res_e  res_o
);
  always_comb begin
    case (sig_i)
      3'b101:  res_o = RES_NORMAL;
      3'b011:  res_o = RES_OPEN;
      3'b000:  res_o = RES_SHORT_GND;
      3'b111:  res_o = RES_SHORT_SUP;
      default: res_o = RES_UNKNOWN;
    endcase
  end
endmodule

// File: rtl/odiag_offstate_seq.sv
module odiag_offstate_seq
  import odiag_pkg::*;
#(
  parameter int NUM_OUT  = 6,
  parameter int SETTLE_W = 8,
  localparam int NUM_PAIRS = NUM_OUT * (NUM_OUT - 1) / 2,
  localparam int SEL_W     = $clog2(NUM_PAIRS + 1),
  localparam int IDX_W     = $clog2(NUM_OUT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [SEL_W-1:0]    pair_sel_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  input  logic [NUM_OUT-1:0]  hb_en_i,
  input  logic                cmp_i,
  output logic [NUM_OUT-1:0]  pu_en_o,
  output logic [NUM_OUT-1:0]  pd_en_o,
  output logic [NUM_OUT-1:0]  cmp_mux_o,
  output logic                ref_high_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [2:0]          result_o
);
  typedef enum logic {ST_IDLE, ST_RUN} st_e;

  st_e                 state_q;
  logic [1:0]          step_q;
  logic [SETTLE_W-1:0] cnt_q;
  logic [IDX_W-1:0]    x_q, y_q;
  logic [1:0]          sig_q;
  logic                done_q;
  diag_res_e           res_q;

  logic             any_en;
  logic             sel_valid;
  logic [IDX_W-1:0] sel_x, sel_y;
  diag_res_e        class_res;
  bias_code_e       code;

  assign any_en = |hb_en_i;

  odiag_pair_decode #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_dec (
    .sel_i   (pair_sel_i),
    .valid_o (sel_valid),
    .x_idx_o (sel_x),
    .y_idx_o (sel_y)
  );

  // Bias is gated combinationally by the bridge enables.
  always_comb begin
    code = BIAS_OFF;
    if (state_q == ST_RUN && !any_en) begin
      case (step_q)
        2'd0:    code = BIAS_XUP_SNS_Y;
        2'd1:    code = BIAS_XUP_SNS_X;
        default: code = BIAS_YUP_SNS_Y;
      endcase
    end
  end

  odiag_bias_map #(.NUM_OUT(NUM_OUT), .IDX_W(IDX_W)) u_bias (
    .code_i     (code),
    .x_idx_i    (x_q),
    .y_idx_i    (y_q),
    .pu_o       (pu_en_o),
    .pd_o       (pd_en_o),
    .mux_o      (cmp_mux_o),
    .ref_high_o (ref_high_o)
  );

  odiag_classify u_cls (
    .sig_i (({sig_q[0], sig_q[1], cmp_i})),
    .res_o (class_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      cnt_q   <= '0;
      x_q     <= '0;
      y_q     <= '0;
      sig_q   <= '0;
      done_q  <= 1'b0;
      res_q   <= RES_NONE;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (any_en) begin
              done_q <= 1'b1;
              res_q  <= RES_ABORT;
            end else if (!sel_valid) begin
              done_q <= 1'b1;
              res_q  <= RES_NONE;
            end else begin
              state_q <= ST_RUN;
              step_q  <= '0;
              cnt_q   <= settle_cycles_i;
              x_q     <= sel_x;
              y_q     <= sel_y;
            end
          end
        end
        default: begin
          if (any_en) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            res_q   <= RES_ABORT;
          end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (step_q == 2'd2) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            res_q   <= class_res;
          end else begin
            sig_q[step_q[0]] <= cmp_i;
            step_q           <= step_q + 2'd1;
            cnt_q            <= settle_cycles_i;
          end
        end
      endcase
    end
  end

  assign busy_o   = (state_q == ST_RUN);
  assign done_o   = done_q;
  assign result_o = res_q;

  // R10: bias removed in the same cycle any bridge is enabled
  a_r10_bias_off_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    any_en |-> (pu_en_o == '0 && pd_en_o == '0 && cmp_mux_o == '0));
  // R10: abort of a running sequence
  a_r10_abort_result: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && any_en) |=> (done_o && result_o == 3'd6));
  // R8: done is a single-cycle pulse and never overlaps busy
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R9: no bias outside a running sequence
  a_r9_idle_no_bias: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (pu_en_o == '0 && pd_en_o == '0 && !ref_high_o));
  // R3: one comparator source at a time, pulls never fight on one pin
  a_r3_mux_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmp_mux_o) && ((pu_en_o & pd_en_o) == '0));
  // R12: a start while busy does not restart the step count
  a_r12_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !any_en && step_q != 2'd0) |=> (step_q != 2'd0 || done_o));
endmodule

// File: tb/odiag_offstate_seq_tb.sv
module odiag_offstate_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] pair_sel_i = '0;
  logic [7:0] settle_cycles_i = '0;
  logic [5:0] hb_en_i = '0;
  logic       cmp_i = 1'b0;
  logic [5:0] pu_en_o, pd_en_o, cmp_mux_o;
  logic       ref_high_o, busy_o, done_o;
  logic [2:0] result_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  odiag_offstate_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pair_sel_i(pair_sel_i),
    .settle_cycles_i(settle_cycles_i), .hb_en_i(hb_en_i), .cmp_i(cmp_i),
    .pu_en_o(pu_en_o), .pd_en_o(pd_en_o), .cmp_mux_o(cmp_mux_o),
    .ref_high_o(ref_high_o), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // R2: lexicographic pair list, 0-based indices
  function automatic void pair_of(input int sel, output int x, output int y);
    int k = 0;
    x = 0; y = 0;
    for (int a = 0; a < 5; a++)
      for (int b = a + 1; b < 6; b++) begin
        k++;
        if (k == sel) begin x = a; y = b; end
      end
  endfunction

  task automatic pulse_start(input int sel, input int settle);
    @(negedge clk);
    pair_sel_i = 4'(sel);
    settle_cycles_i = 8'(settle);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Full run; cmp_i is correct only on the last cycle of each step (R6).
  task automatic run_seq(input string nm, input int sel, input int n0, input int n1,
                         input logic [2:0] sig, input int exp_res, input bit restart);
    int x, y, l0, l1, total;
    pair_of(sel, x, y);
    l0 = n0 + 1; l1 = n1 + 1; total = l0 + 2 * l1;
    pulse_start(sel, n0);
    settle_cycles_i = 8'(n1);
    for (int k = 0; k <= total; k++) begin
      int s;
      logic bitv;
      s = (k < l0) ? 0 : ((k < l0 + l1) ? 1 : 2);
      if (k < total) begin
        chk({nm, " R8 busy"}, int'(busy_o), 1);
        chk({nm, " R8 done low"}, int'(done_o), 0);
        if (s == 0) begin
          chk({nm, " R2/R3/R6 pu"}, int'(pu_en_o), 1 << x);
          chk({nm, " R2/R3/R6 pd"}, int'(pd_en_o), 1 << y);
          chk({nm, " R3 mux"}, int'(cmp_mux_o), 1 << y);
          chk({nm, " R3 ref"}, int'(ref_high_o), 0);
        end else if (s == 1) begin
          chk({nm, " R2/R4/R6 pu"}, int'(pu_en_o), 1 << x);
          chk({nm, " R2/R4/R6 pd"}, int'(pd_en_o), 1 << y);
          chk({nm, " R4 mux"}, int'(cmp_mux_o), 1 << x);
          chk({nm, " R4 ref"}, int'(ref_high_o), 1);
        end else begin
          chk({nm, " R2/R5/R6 pu"}, int'(pu_en_o), 1 << y);
          chk({nm, " R2/R5/R6 pd"}, int'(pd_en_o), 1 << x);
          chk({nm, " R5 mux"}, int'(cmp_mux_o), 1 << y);
          chk({nm, " R5 ref"}, int'(ref_high_o), 0);
        end
        bitv = sig[2 - s];
        if (k + 1 == l0 || k + 1 == l0 + l1 || k + 1 == total) cmp_i = bitv;
        else cmp_i = ~bitv;
        if (restart && k == 1) begin pair_sel_i = 4'd15; start_i = 1'b1; end
        if (restart && k == 2) start_i = 1'b0;
      end else begin
        chk({nm, " R8 done"}, int'(done_o), 1);
        chk({nm, " R8 busy low"}, int'(busy_o), 0);
        chk({nm, " R7 result"}, int'(result_o), exp_res);
        chk({nm, " R8 bias off"}, int'(pu_en_o | pd_en_o), 0);
      end
      @(negedge clk);
    end
    chk({nm, " R8 single pulse"}, int'(done_o), 0);
    chk({nm, " R8 result held"}, int'(result_o), exp_res);
    start_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 result", int'(result_o), 0);
    chk("R1 bias", int'(pu_en_o | pd_en_o | cmp_mux_o), 0);
    chk("R1 ref", int'(ref_high_o), 0);
  endtask

  task automatic t_sel_zero();
    pulse_start(0, 3);
    chk("R9 done", int'(done_o), 1);
    chk("R9 result", int'(result_o), 0);
    chk("R9 busy", int'(busy_o), 0);
    chk("R9 bias", int'(pu_en_o | pd_en_o), 0);
    @(negedge clk);
    chk("R9 pulse end", int'(done_o), 0);
  endtask

  task automatic t_start_enabled();
    hb_en_i = 6'b100000;
    pulse_start(4, 2);
    chk("R11 done", int'(done_o), 1);
    chk("R11 result", int'(result_o), 6);
    chk("R11 busy", int'(busy_o), 0);
    chk("R11 bias", int'(pu_en_o | pd_en_o | cmp_mux_o), 0);
    hb_en_i = '0;
    @(negedge clk);
  endtask

  task automatic t_abort();
    pulse_start(7, 3);
    @(negedge clk);
    chk("R10 running", int'(busy_o), 1);
    hb_en_i = 6'b000100;
    #1;
    chk("R10 pu off now", int'(pu_en_o), 0);
    chk("R10 pd off now", int'(pd_en_o), 0);
    chk("R10 mux off now", int'(cmp_mux_o), 0);
    @(negedge clk);
    chk("R10 done", int'(done_o), 1);
    chk("R10 result", int'(result_o), 6);
    chk("R10 busy", int'(busy_o), 0);
    hb_en_i = '0;
    @(negedge clk);
    chk("R10 stays idle", int'(busy_o | done_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_seq("normal", 1, 2, 2, 3'b101, 1, 1'b0);
    run_seq("open", 6, 3, 3, 3'b011, 2, 1'b0);
    run_seq("gnd", 10, 1, 1, 3'b000, 3, 1'b0);
    run_seq("supply", 15, 0, 0, 3'b111, 4, 1'b0);
    run_seq("indet", 8, 1, 1, 3'b010, 5, 1'b0);
    run_seq("reload", 3, 2, 5, 3'b101, 1, 1'b0);
    run_seq("R12 restart", 3, 2, 2, 3'b011, 2, 1'b1);
    for (int p = 1; p <= 15; p++) run_seq("R2 sweep", p, 0, 0, 3'b101, 1, 1'b0);
    t_sel_zero();
    t_start_enabled();
    t_abort();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule